// File: doc/BRIEF.md
# Omega Multistage Self-Routing Network

This block moves up to N packets per cycle from N input ports to N output ports through log2(N) stages of two-by-two switching elements. A permutation rotates the port order between stages. Each packet carries its own destination index, and each switch sets itself from one bit of that index, so no central controller is needed. The switch count grows as N·log2(N)/2, where a full crossbar needs N² crosspoints. The price is that some sets of destinations cannot all pass in one trip.

When two packets reach the same switch in the same cycle and both need the same output, the packet on the upper (even) input goes on. The other packet is discarded. The block reports the loss by raising a flag on the input port that the discarded packet entered from. This flag appears in the same cycle in which the packet would otherwise have arrived. Every stage ends in a register, so a new set of packets can be injected on every clock. The sender sees which inputs were refused and can try them again later. The block stores nothing beyond the pipeline registers.

Top module: `omega_net`

## Requirements
- R1: N is a power of two and the network has K = log2(N) stages. A valid packet that is not discarded appears on the output port whose index equals its K-bit destination. It arrives exactly K clock cycles after the edge that samples it, with its data word unchanged.
- R2: Before stage s, a packet at position p moves to the position whose K-bit index is p rotated left by one. In stage s, bit K-1-s of the destination (most significant bit first) sets the lowest bit of the position. A value of 0 takes the upper (even) output of the switch and a value of 1 takes the lower (odd) output.
- R3: A conflict occurs when two valid packets at one switch need the same output. The packet on the even input proceeds and the packet on the odd input is discarded. `in_blocked` is then raised at the discarded packet's source port exactly K cycles after injection, and no output carries that packet.
- R4: An input whose `in_valid` bit is 0 takes part in no conflict and produces no output. An output port that no packet reaches holds `out_valid` at 0.
- R5: Each valid input produces exactly one outcome: either a delivery or its `in_blocked` bit. It never produces both, and it never produces neither.
- R6: While `rst_n` is low, `out_valid` and `in_blocked` read all zeros, whatever the inputs are.
- R7: A new set of packets can be injected on every cycle. Packet sets injected on different cycles never block or alter one another.
- R8: A single valid packet, sent from any source to any destination, is never discarded. When every input sends to its own index, no packet is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | One bit per input port: a packet is present |
| in_dest | input | N*K | Destination index of each input, port i at bits [i*K +: K] |
| in_data | input | N*W | Data word of each input, port i at bits [i*W +: W] |
| out_valid | output | N | One bit per output port: a packet has arrived |
| out_data | output | N*W | Data word on each output, port j at bits [j*W +: W] |
| in_blocked | output | N | Bit i is high when the packet injected on input i K cycles earlier was discarded |

## Verification
Delivery and discard happen together whenever one switch receives two packets that need the same side. In that cycle the survivor must appear at its destination and the loser's source flag must rise. The bench provokes this case with random partial permutations, with random destinations that repeat, and with sets in which every input names the same destination. These are streamed back to back. A bench-side route model walks each set through the rotate-and-set steps and decides which packets survive. The bench then compares the valid bits, the flags and every delivered data word on the cycle that lies K cycles after injection.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Position reached by the inter-stage rotation: rotate the k-bit index left by one.
    function automatic int shuffle_pos(input int p, input int k);
        return ((p << 1) | (p >> (k - 1))) & ((1 << k) - 1);
    endfunction

endpackage

// File: rtl/omega_switch.sv
module omega_switch (
    input  logic a_vld,     // packet on the upper (even) input
    input  logic a_bit,     // its routing bit for this stage
    input  logic b_vld,     // packet on the lower (odd) input
    input  logic b_bit,
    output logic up_vld,
    output logic up_sel_b,  // upper output carries input b
    output logic dn_vld,
    output logic dn_sel_b,  // lower output carries input b
    output logic b_drop     // input b lost the conflict
);
    logic clash;
    logic a_up, a_dn, b_up, b_dn;

    always_comb begin
        clash    = a_vld & b_vld & (a_bit == b_bit);
        a_up     = a_vld & ~a_bit;
        a_dn     = a_vld &  a_bit;
        b_up     = b_vld & ~b_bit & ~clash;
        b_dn     = b_vld &  b_bit & ~clash;
        up_vld   = a_up | b_up;
        up_sel_b = b_up;
        dn_vld   = a_dn | b_dn;
        dn_sel_b = b_dn;
        b_drop   = clash;
    end
endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N     = 8,
    parameter int K     = 3,
    parameter int W     = 16,
    parameter int STAGE = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   vld_i,
    input  logic [N*K-1:0] dst_i,
    input  logic [N*K-1:0] src_i,
    input  logic [N*W-1:0] dat_i,
    input  logic [N-1:0]   drop_i,
    output logic [N-1:0]   vld_o,
    output logic [N*K-1:0] dst_o,
    output logic [N*K-1:0] src_o,
    output logic [N*W-1:0] dat_o,
    output logic [N-1:0]   drop_o
);
    localparam int BIT   = K - 1 - STAGE;
    localparam int PAIRS = N / 2;

    logic [N-1:0]     sh_vld;
    logic [N*K-1:0]   sh_dst;
    logic [N*K-1:0]   sh_src;
    logic [N*W-1:0]   sh_dat;
    logic [N-1:0]     nx_vld;
    logic [N*K-1:0]   nx_dst;
    logic [N*K-1:0]   nx_src;
    logic [N*W-1:0]   nx_dat;
    logic [N-1:0]     drop_nx;
    logic [PAIRS-1:0] clash;

    // Rotation wiring in front of the switch column
    for (genvar p = 0; p < N; p++) begin : g_shuffle
        localparam int Q = shuffle_pos(p, K);
        assign sh_vld[Q]         = vld_i[p];
        assign sh_dst[Q*K +: K]  = dst_i[p*K +: K];
        assign sh_src[Q*K +: K]  = src_i[p*K +: K];
        assign sh_dat[Q*W +: W]  = dat_i[p*W +: W];
    end

    // Column of 2x2 elements
    for (genvar j = 0; j < PAIRS; j++) begin : g_pair
        localparam int UP = 2 * j;
        localparam int DN = 2 * j + 1;
        logic up_sel_b;
        logic dn_sel_b;

        omega_switch u_sw (
            .a_vld   (sh_vld[UP]),
            .a_bit   (sh_dst[UP*K + BIT]),
            .b_vld   (sh_vld[DN]),
            .b_bit   (sh_dst[DN*K + BIT]),
            .up_vld  (nx_vld[UP]),
            .up_sel_b(up_sel_b),
            .dn_vld  (nx_vld[DN]),
            .dn_sel_b(dn_sel_b),
            .b_drop  (clash[j])
        );

        assign nx_dst[UP*K +: K] = up_sel_b ? sh_dst[DN*K +: K] : sh_dst[UP*K +: K];
        assign nx_dst[DN*K +: K] = dn_sel_b ? sh_dst[DN*K +: K] : sh_dst[UP*K +: K];
        assign nx_src[UP*K +: K] = up_sel_b ? sh_src[DN*K +: K] : sh_src[UP*K +: K];
        assign nx_src[DN*K +: K] = dn_sel_b ? sh_src[DN*K +: K] : sh_src[UP*K +: K];
        assign nx_dat[UP*W +: W] = up_sel_b ? sh_dat[DN*W +: W] : sh_dat[UP*W +: W];
        assign nx_dat[DN*W +: W] = dn_sel_b ? sh_dat[DN*W +: W] : sh_dat[UP*W +: W];
    end

    // Mark the source port of every packet lost in this column
    always_comb begin
        drop_nx = drop_i;
        for (int j = 0; j < PAIRS; j++) begin
            if (clash[j]) begin
                drop_nx[sh_src[(2*j+1)*K +: K]] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_o  <= '0;
            drop_o <= '0;
        end else begin
            vld_o  <= nx_vld;
            drop_o <= drop_nx;
        end
    end

    always_ff @(posedge clk) begin
        dst_o <= nx_dst;
        src_o <= nx_src;
        dat_o <= nx_dat;
    end
endmodule

// File: rtl/omega_net.sv
module omega_net
    import omega_pkg::*;
#(
    parameter int  N = 8,
    parameter int  W = 16,
    localparam int K = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   in_valid,
    input  logic [N*K-1:0] in_dest,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   out_valid,
    output logic [N*W-1:0] out_data,
    output logic [N-1:0]   in_blocked
);
    // Stage-input bundles, index s feeds stage s
    logic [N-1:0]   vld_c  [K];
    logic [N*K-1:0] dst_c  [K];
    logic [N*K-1:0] src_c  [K];
    logic [N*W-1:0] dat_c  [K];
    logic [N-1:0]   drop_c [K];

    assign vld_c[0]  = in_valid;
    assign dst_c[0]  = in_dest;
    assign dat_c[0]  = in_data;
    assign drop_c[0] = '0;

    for (genvar p = 0; p < N; p++) begin : g_src_tag
        assign src_c[0][p*K +: K] = K'(p);
    end

    for (genvar s = 0; s < K; s++) begin : g_stage
        logic [N-1:0]   vld_q;
        logic [N*K-1:0] dst_q_unused_at_last;
        logic [N*K-1:0] src_q_unused_at_last;
        logic [N*W-1:0] dat_q;
        logic [N-1:0]   drop_q;

        omega_stage #(
            .N    (N),
            .K    (K),
            .W    (W),
            .STAGE(s)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_c[s]),
            .dst_i (dst_c[s]),
            .src_i (src_c[s]),
            .dat_i (dat_c[s]),
            .drop_i(drop_c[s]),
            .vld_o (vld_q),
            .dst_o (dst_q_unused_at_last),
            .src_o (src_q_unused_at_last),
            .dat_o (dat_q),
            .drop_o(drop_q)
        );

        if (s < K - 1) begin : g_link
            assign vld_c[s+1]  = vld_q;
            assign dst_c[s+1]  = dst_q_unused_at_last;
            assign src_c[s+1]  = src_q_unused_at_last;
            assign dat_c[s+1]  = dat_q;
            assign drop_c[s+1] = drop_q;
        end else begin : g_exit
            assign out_valid  = vld_q;
            assign out_data   = dat_q;
            assign in_blocked = drop_q;
        end
    end
endmodule

// File: rtl/omega_net_chk.sv
module omega_net_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] in_valid,
    input logic [N-1:0] out_valid,
    input logic [N-1:0] in_blocked
);
    localparam int K = $clog2(N);

    // Delayed copy of the injected valid mask, aligned with the outputs
    logic [N-1:0] vpipe [K];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < K; i++) vpipe[i] <= '0;
        end else begin
            vpipe[0] <= in_valid;
            for (int i = 1; i < K; i++) vpipe[i] <= vpipe[i-1];
        end
    end

    // R5
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(out_valid) + $countones(in_blocked)) == $countones(vpipe[K-1]));

    // R3
    blocked_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blocked & ~vpipe[K-1]) == '0);

    // R8
    single_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(vpipe[K-1]) == 1) |-> (in_blocked == '0 && $countones(out_valid) == 1));

    // R4
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vpipe[K-1] == '0) |-> (out_valid == '0 && in_blocked == '0));
endmodule

bind omega_net omega_net_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .in_blocked(in_blocked)
);

// File: tb/omega_net_tb_top.sv
`timescale 1ns/1ps
module omega_net_tb_top;
    localparam int N  = 8;
    localparam int K  = 3;
    localparam int W  = 16;
    localparam int NV = 500;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N-1:0]   in_valid;
    logic [N*K-1:0] in_dest;
    logic [N*W-1:0] in_data;
    logic [N-1:0]   out_valid;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   in_blocked;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int nv     = 0;

    logic [N-1:0] vval [NV];
    int           vdst [NV][N];
    logic [W-1:0] vdat [NV][N];
    string        vtag [NV];
    logic [N-1:0] eval [NV];
    logic [N-1:0] eblk [NV];
    logic [W-1:0] edat [NV][N];

    always #2.5 clk = ~clk;

    omega_net #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .in_blocked(in_blocked)
    );

    function automatic int rotl(int p);
        return ((p << 1) | (p >> (K - 1))) & (N - 1);
    endfunction

    // Route model: rotate positions, then set the low position bit from the
    // destination bit, even input winning a clash (R2, R3).
    task automatic ref_route(int v);
        bit pv[N]; int pd[N]; int ps[N];
        bit nvd[N]; int nd[N]; int ns[N];
        for (int p = 0; p < N; p++) begin
            pv[p] = vval[v][p]; pd[p] = vdst[v][p]; ps[p] = p;
        end
        eblk[v] = '0;
        for (int s = 0; s < K; s++) begin
            int b = K - 1 - s;
            for (int p = 0; p < N; p++) begin
                nvd[rotl(p)] = pv[p]; nd[rotl(p)] = pd[p]; ns[rotl(p)] = ps[p];
            end
            for (int j = 0; j < N/2; j++) begin
                int ba, bb;
                ba = (nd[2*j] >> b) & 1;
                bb = (nd[2*j+1] >> b) & 1;
                pv[2*j] = 0; pv[2*j+1] = 0;
                if (nvd[2*j]) begin
                    pv[2*j+ba] = 1; pd[2*j+ba] = nd[2*j]; ps[2*j+ba] = ns[2*j];
                end
                if (nvd[2*j+1]) begin
                    if (nvd[2*j] && ba == bb) eblk[v][ns[2*j+1]] = 1'b1;
                    else begin
                        pv[2*j+bb] = 1; pd[2*j+bb] = nd[2*j+1]; ps[2*j+bb] = ns[2*j+1];
                    end
                end
            end
        end
        eval[v] = '0;
        for (int p = 0; p < N; p++) begin
            edat[v][p] = '0;
            if (pv[p]) begin
                eval[v][p] = 1'b1;
                edat[v][p] = vdat[v][ps[p]];
            end
        end
    endtask

    task automatic add_vec(logic [N-1:0] m, int d[N], string tag);
        vval[nv] = m;
        for (int p = 0; p < N; p++) begin
            vdst[nv][p] = d[p];
            vdat[nv][p] = W'($urandom);
        end
        vtag[nv] = tag;
        ref_route(nv);
        nv++;
    endtask

    task automatic build_vectors();
        int d[N];
        // R8: every single source/destination pair
        for (int s = 0; s < N; s++)
            for (int t = 0; t < N; t++) begin
                for (int p = 0; p < N; p++) d[p] = (p * 5 + 3) % N;
                d[s] = t;
                add_vec(N'(1) << s, d, "R8 single");
            end
        // R8: identity; cyclic shifts and bit reversal
        for (int c = 0; c < N; c++) begin
            for (int p = 0; p < N; p++) d[p] = (p + c) % N;
            add_vec('1, d, (c == 0) ? "R8 identity" : "R2 shift");
        end
        for (int p = 0; p < N; p++) d[p] = {p[0], p[1], p[2]};
        add_vec('1, d, "R2 bitrev");
        // R3: all inputs name one destination
        for (int t = 0; t < N; t++) begin
            for (int p = 0; p < N; p++) d[p] = t;
            add_vec('1, d, "R3 hotspot");
        end
        // R4: idle sets
        for (int i = 0; i < 4; i++) begin
            for (int p = 0; p < N; p++) d[p] = p;
            add_vec('0, d, "R4 idle");
        end
        // R3/R4: random partial permutations
        for (int i = 0; i < 300; i++) begin
            for (int p = 0; p < N; p++) d[p] = p;
            for (int p = N - 1; p > 0; p--) begin
                int r = $urandom_range(0, p);
                int tmp = d[p]; d[p] = d[r]; d[r] = tmp;
            end
            add_vec(N'($urandom) | N'($urandom), d, "R3 partial perm");
        end
        // R3/R5: random destinations with repeats
        while (nv < NV) begin
            for (int p = 0; p < N; p++) d[p] = $urandom_range(0, N - 1);
            add_vec(N'($urandom), d, "R5 random dest");
        end
    endtask

    task automatic drive(int v);
        in_valid = vval[v];
        for (int p = 0; p < N; p++) begin
            in_dest[p*K +: K] = K'(vdst[v][p]);
            in_data[p*W +: W] = vdat[v][p];
        end
    endtask

    task automatic compare(int v);
        checks++;
        if (out_valid !== eval[v]) begin
            errors++;
            $display("FAIL R1 R2 R4 out_valid (%s) vec %0d: actual %b expected %b",
                     vtag[v], v, out_valid, eval[v]);
        end
        checks++;
        if (in_blocked !== eblk[v]) begin
            errors++;
            $display("FAIL R3 R5 in_blocked (%s) vec %0d: actual %b expected %b",
                     vtag[v], v, in_blocked, eblk[v]);
        end
        for (int p = 0; p < N; p++) begin
            if (eval[v][p]) begin
                checks++;
                if (out_data[p*W +: W] !== edat[v][p]) begin
                    errors++;
                    $display("FAIL R1 R7 out_data[%0d] (%s) vec %0d: actual %h expected %h",
                             p, vtag[v], v, out_data[p*W +: W], edat[v][p]);
                end
            end
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = '1;
        in_dest  = '0;
        in_data  = '1;
        build_vectors();
        // R6: outputs quiet under reset even with all inputs valid
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== '0 || in_blocked !== '0) begin
            errors++;
            $display("FAIL R6 reset: actual valid %b blocked %b expected 0 0",
                     out_valid, in_blocked);
        end
        in_valid = '0;
        rst_n    = 1'b1;
        // R7: one set per cycle, checked K cycles after injection
        for (int c = 0; c < nv + K; c++) begin
            @(negedge clk);
            if (c >= K) compare(c - K);
            if (c < nv) drive(c);
            else in_valid = '0;
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule